// File: doc/BRIEF.md
# Prioritised Peripheral Interrupt Aggregator

This block gathers three peripheral interrupt sources and presents them to a processor core as one combined peripheral request line. The sources are a trip input that is active low, a synchronisation pulse from the PWM unit, and a shared change-of-state interrupt drawn from a group of general-purpose port lines. Each source has its own edge rule. Each source sets its own latched flag bit, and software clears that bit by writing a one to it.

A mask register gates each source's flag into the combined request. The mask does not stop a flag from latching. A fixed-priority encoder reports the highest pending source that is not masked, as a 2-bit vector index with a valid bit. The combined request reaches the core only while the core-side peripheral enable (`core_irq_en`) is high.

All inputs are synchronous to `clk`. A flag becomes visible one cycle after the clock edge at which the qualifying input edge is sampled. The vector outputs and `irq_out` follow the flag, mask and core-enable state combinationally.

Top module: `periph_irq_merge`

## Requirements
- R1: After reset, the following all read zero: `flags`, `mask`, `vec_valid`, `vec_idx` and `irq_out`.
- R2: A low-to-high transition of `sync_pulse` sets flag bit 1. A high-to-low transition leaves it unchanged.
- R3: A high-to-low transition of `trip_n` sets flag bit 0. A low-to-high transition leaves it unchanged.
- R4: A change in either direction on a line of `port_in` whose `port_ie` bit is 1 sets flag bit 2. Changes on lines whose `port_ie` bit is 0 have no effect.
- R5: Once set, a flag bit stays set until a cycle with `flag_clr_wr` high and a 1 in the matching bit of `wdata`. Bits written 0 are unchanged.
- R6: If a qualifying edge arrives in the same cycle as a clear of its flag bit, the flag bit remains set.
- R7: A cycle with `mask_wr` high loads `wdata` into `mask`, where 1 enables a source. A flag whose mask bit is 0 still latches.
- R8: `vec_valid` is 1 when any bit of `flags & mask` is set. `vec_idx` then gives the highest-priority such bit: 0 for trip, 1 for sync, 2 for port. When nothing is pending, `vec_idx` is 0.
- R9: `irq_out` is 1 exactly when `vec_valid` is 1 and `core_irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_pulse | input | 1 | PWM synchronisation pulse; rising edge is the event |
| trip_n | input | 1 | Active-low trip input; falling edge is the event |
| port_in | input | GPIO_W | General-purpose port lines |
| port_ie | input | GPIO_W | Per-line change-interrupt enable |
| flag_clr_wr | input | 1 | Write-one-to-clear strobe for `flags` |
| mask_wr | input | 1 | Load strobe for `mask` |
| wdata | input | 3 | Write data for both registers (bit0 trip, bit1 sync, bit2 port) |
| core_irq_en | input | 1 | Core-side enable for the combined peripheral request |
| flags | output | 3 | Latched source flags |
| mask | output | 3 | Source enable mask |
| vec_valid | output | 1 | Some unmasked flag is pending |
| vec_idx | output | 2 | Index of highest-priority pending source |
| irq_out | output | 1 | Combined peripheral request into the core |

## Verification
The embedded assertions check the following on every cycle:
- A falling trip edge or a rising sync edge is always followed by its flag.
- A flag bit never drops without a clear written for it.
- The reported index never skips a higher-priority pending source.
- The combined line never rises while the core enable is low or nothing is pending.

Some behaviours can only be shown through the bench's scenarios:
- An edge of the wrong polarity leaves its flag unchanged.
- A port line whose enable is 0 is ignored.
- An edge that coincides with a clear still wins.
- The full encoder behaviour, which the bench sweeps across every flag, mask and core-enable combination.

// File: rtl/periph_irq_merge.sv
module periph_irq_merge #(
  parameter int GPIO_W = 9,
  localparam int NSRC  = 3,
  localparam int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_pulse,
  input  logic              trip_n,
  input  logic [GPIO_W-1:0] port_in,
  input  logic [GPIO_W-1:0] port_ie,
  input  logic              flag_clr_wr,
  input  logic              mask_wr,
  input  logic [NSRC-1:0]   wdata,
  input  logic              core_irq_en,
  output logic [NSRC-1:0]   flags,
  output logic [NSRC-1:0]   mask,
  output logic              vec_valid,
  output logic [IDX_W-1:0]  vec_idx,
  output logic              irq_out
);

  logic              sync_q, trip_q;
  logic [GPIO_W-1:0] port_q;
  logic [NSRC-1:0]   hit, clr, pend;

  assign hit[0] =  trip_q & ~trip_n;
  assign hit[1] = ~sync_q &  sync_pulse;
  assign hit[2] = |((port_in ^ port_q) & port_ie);
  assign clr    = flag_clr_wr ? wdata : '0;
  assign pend   = flags & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      trip_q <= 1'b1;
      port_q <= '0;
      flags  <= '0;
      mask   <= '0;
    end else begin
      sync_q <= sync_pulse;
      trip_q <= trip_n;
      port_q <= port_in;
      flags  <= (flags & ~clr) | hit;
      if (mask_wr) mask <= wdata;
    end
  end

  always_comb begin
    vec_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) vec_idx = IDX_W'(i);
  end

  assign vec_valid = |pend;
  assign irq_out   = vec_valid & core_irq_en;

  assert_trip_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trip_n) |=> flags[0]);

  assert_sync_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_pulse) |=> flags[1]);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != '0) && !flag_clr_wr |=> ((flags & $past(flags)) == $past(flags)));

  assert_prio_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_idx != 2'd0 |-> !(flags[0] && mask[0]));

  assert_prio_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_idx == 2'd2 |-> !(flags[1] && mask[1]));

  assert_line_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> core_irq_en && (flags & mask) != '0);

endmodule

// File: tb/periph_irq_merge_tb.sv
`timescale 1ns/1ps
module periph_irq_merge_tb_top;
  localparam int GW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sync_pulse, trip_n, flag_clr_wr, mask_wr, core_irq_en;
  logic [GW-1:0] port_in, port_ie;
  logic [2:0]    wdata, flags, mask;
  logic          vec_valid, irq_out;
  logic [1:0]    vec_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  periph_irq_merge #(.GPIO_W(GW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .trip_n(trip_n),
    .port_in(port_in), .port_ie(port_ie), .flag_clr_wr(flag_clr_wr),
    .mask_wr(mask_wr), .wdata(wdata), .core_irq_en(core_irq_en),
    .flags(flags), .mask(mask), .vec_valid(vec_valid), .vec_idx(vec_idx),
    .irq_out(irq_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    flag_clr_wr = 1'b1; wdata = 3'b111;
    tick();
    flag_clr_wr = 1'b0; wdata = 3'b000;
  endtask

  task automatic set_mask(input logic [2:0] m);
    mask_wr = 1'b1; wdata = m;
    tick();
    mask_wr = 1'b0; wdata = 3'b000;
  endtask

  // raise the flags selected by p through real input edges (port line 0 enabled)
  task automatic raise(input logic [2:0] p);
    if (p[0]) trip_n = 1'b0;
    if (p[1]) sync_pulse = 1'b1;
    if (p[2]) port_in[0] = ~port_in[0];
    tick();
    trip_n = 1'b1; sync_pulse = 1'b0;
    tick();
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync_pulse = 1'b0; trip_n = 1'b1; port_in = '0; port_ie = '0;
    flag_clr_wr = 1'b0; mask_wr = 1'b0; wdata = '0; core_irq_en = 1'b1;
    repeat (3) tick();
    check("R1 flags", flags, 0);
    check("R1 mask", mask, 0);
    check("R1 valid", vec_valid, 0);
    check("R1 idx", vec_idx, 0);
    check("R1 irq", irq_out, 0);
    rst_n = 1'b1;
    tick();

    // R2 / R3 polarity
    set_mask(3'b111);
    sync_pulse = 1'b1; tick();
    check("R2 rise sets", flags[1], 1);
    clear_all();
    sync_pulse = 1'b0; tick();
    check("R2 fall ignored", flags[1], 0);
    trip_n = 1'b0; tick();
    check("R3 fall sets", flags[0], 1);
    clear_all();
    trip_n = 1'b1; tick();
    check("R3 rise ignored", flags[0], 0);
    check("R3 no irq after rise", irq_out, 0);

    // R4 per-line sweep, both directions over time
    for (int i = 0; i < GW; i++) begin
      port_ie = GW'(1) << i;
      for (int j = 0; j < GW; j++) begin
        port_in[j] = ~port_in[j];
        tick();
        check("R4 port change", flags[2], (i == j) ? 1 : 0);
        clear_all();
      end
    end
    port_ie = GW'(1);

    // R5 selective clear and write-zero
    raise(3'b111);
    check("R5 all set", flags, 3'b111);
    flag_clr_wr = 1'b1; wdata = 3'b000; tick();
    check("R5 write zero keeps", flags, 3'b111);
    wdata = 3'b010; tick();
    flag_clr_wr = 1'b0; wdata = 3'b000;
    check("R5 clear sync only", flags, 3'b101);
    repeat (4) tick();
    check("R5 sticky", flags, 3'b101);

    // R6 edge wins over clear
    clear_all();
    raise(3'b001);
    flag_clr_wr = 1'b1; wdata = 3'b001; trip_n = 1'b0; tick();
    flag_clr_wr = 1'b0; wdata = 3'b000; trip_n = 1'b1;
    check("R6 trip collision", flags[0], 1);
    flag_clr_wr = 1'b1; wdata = 3'b010; sync_pulse = 1'b1; tick();
    flag_clr_wr = 1'b0; wdata = 3'b000; sync_pulse = 1'b0;
    check("R6 sync collision", flags[1], 1);

    // R7 masked source still latches
    clear_all();
    set_mask(3'b000);
    check("R7 mask loaded", mask, 0);
    raise(3'b111);
    check("R7 masked latch", flags, 3'b111);
    check("R7 masked no valid", vec_valid, 0);
    check("R7 masked no irq", irq_out, 0);

    // R8 / R9 exhaustive sweep of flags x mask x core enable
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 8; p++) begin
        clear_all();
        set_mask(3'(m));
        raise(3'(p));
        for (int ce = 0; ce < 2; ce++) begin
          logic [2:0] pd;
          logic [1:0] ei;
          core_irq_en = ce[0];
          #1;
          pd = 3'(p) & 3'(m);
          ei = pd[0] ? 2'd0 : pd[1] ? 2'd1 : pd[2] ? 2'd2 : 2'd0;
          check("R7 flags", flags, p);
          check("R8 valid", vec_valid, (pd != 0) ? 1 : 0);
          check("R8 idx", vec_idx, ei);
          check("R9 irq", irq_out, ((pd != 0) && ce == 1) ? 1 : 0);
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule